// File: doc/BRIEF.md
# Card Status Change Interrupt Controller

This block sits in a card-slot bridge and turns four slow status lines from the socket into one interrupt for the host. The four lines are card detect change, ready change, battery warning and battery dead. Each line passes through a synchronizer. A rising edge on a line sets a sticky flag in a status register. Each flag is then masked by its own enable bit, and the surviving flags are ORed together. A routing qualification gates that result, and a flop registers it as the PCI-style interrupt output.

A byte-wide register port with an 8-bit address reaches four registers:

- **Slot control (0x03):** card reset release, card type and a routing enable.
- **Status (0x04):** read-only. A read returns the latched flags and clears them.
- **Event configuration (0x05):** the per-event enables and a four-bit steering select field.
- **Diagnostic (0x93).**

Bit 5 of the diagnostic register picks how routing is qualified. With the bit set, routing is open only while the steering select field is zero. With the bit clear, the control register's routing enable opens it. Software must read the status register to acknowledge events. Until it does, the interrupt stays high.

Top module: `csc_irq_top`

## Requirements
- R1: After reset, every register reads 0x00, `pci_irq` is 0 and `card_run` is 0 (card held in reset).
- R2: A rising edge on an `evt_in` bit sets its status flag a fixed number of cycles later. The flag stays set after the input falls. A falling edge sets nothing.
- R3: The status register at 0x04 places flags as follows: bit 3 is card detect change (`evt_in[3]`), bit 2 is ready change (`evt_in[2]`), bit 1 is battery warning (`evt_in[1]`) and bit 0 is battery dead (`evt_in[0]`). Bits 7:4 read 0.
- R4: A read of 0x04 returns the flags held before the read and clears all of them. Once the flags are cleared, `pci_irq` falls on the following clock.
- R5: If a new rising edge is registered in the same cycle as the clear from a status read, that flag ends up set. The read still returns the older flags.
- R6: `pci_irq` is registered. It is 1 exactly when routing is open and some status flag has its enable set. Enables are bits 3:0 of 0x05, in the status bit order. A disabled event still latches its flag.
- R7: With diagnostic bit 5 (register 0x93) clear, routing is open exactly when bit 4 of 0x03 is 1.
- R8: With diagnostic bit 5 set, routing is open exactly when bits 7:4 of 0x05 are 0000. In this mode bit 4 of 0x03 has no effect.
- R9: Registers 0x03, 0x05 and 0x93 read back the byte last written. Bit 6 of 0x03 drives `card_run` (0 = reset, 1 = normal). Bit 5 of 0x03 drives `card_io` (1 = I/O card, 0 = memory card).
- R10: Writes to 0x04 and to unmapped addresses change nothing. Reads of unmapped addresses return 0x00.
- R11: If the status register is never read, `pci_irq` stays asserted indefinitely.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | 4 | Asynchronous status lines: [3] detect, [2] ready, [1] battery warn, [0] battery dead |
| bus_addr | input | 8 | Register index |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 8 | Read data, valid the cycle after the strobe |
| pci_irq | output | 1 | Registered interrupt request |
| card_run | output | 1 | Card reset release (0 holds the card in reset) |
| card_io | output | 1 | Card type select (1 = I/O, 0 = memory) |

## Verification
The hardest case to reach from the ports is the collision between a status read and a fresh edge. The flag is set two clocks behind the synchronizer, so the clear and the set must land on the same clock edge. The bench first latches a different event. It then raises the detect line and asserts the read strobe exactly two falling edges later. It checks that the read returns only the older flag and that a second read returns the detect flag. Around this case, the bench sweeps all 256 combinations of event pattern and enable mask. It also sweeps all 64 settings of diagnostic mode, control enable and select field, and compares each interrupt level with the value computed from the rules.

// File: rtl/csc_pkg.sv
package csc_pkg;

    localparam int NUM_EVT = 4;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 8;

    localparam logic [ADDR_W-1:0] IDX_SLOT_CTL = 8'h03;
    localparam logic [ADDR_W-1:0] IDX_STATUS   = 8'h04;
    localparam logic [ADDR_W-1:0] IDX_EVT_CFG  = 8'h05;
    localparam logic [ADDR_W-1:0] IDX_DIAG     = 8'h93;

    // Slot control register layout
    typedef struct packed {
        logic       rsv7;
        logic       card_run;     // 0 = card in reset
        logic       card_io;      // 1 = I/O card
        logic       route_en;     // routing enable when diag gate clear
        logic [3:0] rsv_lo;
    } slot_ctl_t;

    // Event configuration register layout
    typedef struct packed {
        logic [3:0]         steer_sel;
        logic [NUM_EVT-1:0] evt_en;
    } evt_cfg_t;

    // Diagnostic register layout
    typedef struct packed {
        logic [1:0] rsv_hi;
        logic       sel_gate;     // 1 = qualify routing by zero select field
        logic [4:0] rsv_lo;
    } diag_t;

    // Status flags, bit order fixed by the status register
    typedef struct packed {
        logic det_chg;
        logic rdy_chg;
        logic bat_warn;
        logic bat_dead;
    } evt_flags_t;

    function automatic logic route_open(slot_ctl_t ctl, evt_cfg_t cfg, diag_t dg);
        if (dg.sel_gate)
            return (cfg.steer_sel == 4'b0000);
        else
            return ctl.route_en;
    endfunction

    function automatic logic any_pending(evt_flags_t st, evt_cfg_t cfg);
        return |(st & cfg.evt_en);
    endfunction

endpackage

// File: rtl/csc_edge_sync.sv
module csc_edge_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] rise
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] prev_q;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                chain_q <= '0;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], async_in[b]};
            end
        end
        assign rise[b] = chain_q[LAST] & ~prev_q[b];

        always_ff @(posedge clk) begin
            if (rst) prev_q[b] <= 1'b0;
            else     prev_q[b] <= chain_q[LAST];
        end
    end

    // R2: a detected edge never repeats on consecutive cycles
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
        |rise |=> ((rise & $past(rise)) == '0));

endmodule

// File: rtl/csc_status_latch.sv
module csc_status_latch
    import csc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [NUM_EVT-1:0] set_pulse,
    input  logic       rd_clear,
    output evt_flags_t flags
);
    logic [NUM_EVT-1:0] flags_q;
    logic [NUM_EVT-1:0] keep;

    always_comb begin
        keep = rd_clear ? '0 : flags_q;
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= keep | set_pulse;   // new edge wins over clear
    end

    assign flags = evt_flags_t'(flags_q);

    // R2: flags are sticky while no read clears them
    a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
        !rd_clear |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    // R4: a read with no concurrent edge empties the register
    a_r4_clear: assert property (@(posedge clk) disable iff (rst)
        (rd_clear && set_pulse == '0) |=> (flags_q == '0));

    // R5: a concurrent edge survives the clear
    a_r5_new_wins: assert property (@(posedge clk) disable iff (rst)
        (|set_pulse) |=> ((flags_q & $past(set_pulse)) == $past(set_pulse)));

endmodule

// File: rtl/csc_regs.sv
module csc_regs
    import csc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  evt_flags_t        flags,
    output slot_ctl_t         slot_ctl,
    output evt_cfg_t          evt_cfg,
    output diag_t             diag,
    output logic              rd_clear
);
    logic [DATA_W-1:0] rd_mux;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_ctl <= '0;
            evt_cfg  <= '0;
            diag     <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                IDX_SLOT_CTL: slot_ctl <= slot_ctl_t'(bus_wdata);
                IDX_EVT_CFG:  evt_cfg  <= evt_cfg_t'(bus_wdata);
                IDX_DIAG:     diag     <= diag_t'(bus_wdata);
                default: ;
            endcase
        end
    end

    always_comb begin
        case (bus_addr)
            IDX_SLOT_CTL: rd_mux = slot_ctl;
            IDX_STATUS:   rd_mux = {{(DATA_W-NUM_EVT){1'b0}}, flags};
            IDX_EVT_CFG:  rd_mux = evt_cfg;
            IDX_DIAG:     rd_mux = diag;
            default:      rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    assign rd_clear = bus_rd && (bus_addr == IDX_STATUS);

    // R10: a write to an unmapped index leaves all configuration unchanged
    a_r10_unmapped_wr: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr != IDX_SLOT_CTL && bus_addr != IDX_EVT_CFG &&
         bus_addr != IDX_DIAG) |=> ($stable(slot_ctl) && $stable(evt_cfg) && $stable(diag)));

endmodule

// File: rtl/csc_irq_top.sv
module csc_irq_top
    import csc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  evt_in,
    input  logic [7:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [7:0]  bus_wdata,
    input  logic        bus_rd,
    output logic [7:0]  bus_rdata,
    output logic        pci_irq,
    output logic        card_run,
    output logic        card_io
);
    logic [NUM_EVT-1:0] rise;
    evt_flags_t         flags;
    slot_ctl_t          slot_ctl;
    evt_cfg_t           evt_cfg;
    diag_t              diag;
    logic               rd_clear;

    csc_edge_sync #(.WIDTH(NUM_EVT), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (evt_in),
        .rise     (rise)
    );

    csc_status_latch u_stat (
        .clk       (clk),
        .rst       (rst),
        .set_pulse (rise),
        .rd_clear  (rd_clear),
        .flags     (flags)
    );

    csc_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .flags     (flags),
        .slot_ctl  (slot_ctl),
        .evt_cfg   (evt_cfg),
        .diag      (diag),
        .rd_clear  (rd_clear)
    );

    always_ff @(posedge clk) begin
        if (rst) pci_irq <= 1'b0;
        else     pci_irq <= any_pending(flags, evt_cfg) && route_open(slot_ctl, evt_cfg, diag);
    end

    assign card_run = slot_ctl.card_run;
    assign card_io  = slot_ctl.card_io;

    // R6: the interrupt only follows an enabled pending flag
    a_r6_cause: assert property (@(posedge clk) disable iff (rst)
        pci_irq |-> $past(|(flags & evt_cfg.evt_en)));

    // R7: control-bit mode blocks routing when the enable is clear
    a_r7_ctl_block: assert property (@(posedge clk) disable iff (rst)
        (!diag.sel_gate && !slot_ctl.route_en) |=> !pci_irq);

    // R8: select-gated mode blocks routing for any non-zero select
    a_r8_sel_block: assert property (@(posedge clk) disable iff (rst)
        (diag.sel_gate && evt_cfg.steer_sel != 4'b0000) |=> !pci_irq);

endmodule

// File: tb/csc_irq_top_bench.sv
`timescale 1ns/1ps
module csc_irq_top_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] evt_in = '0;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic       pci_irq, card_run, card_io;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    csc_irq_top u_csc_irq_top (
        .clk(clk), .rst(rst), .evt_in(evt_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .pci_irq(pci_irq), .card_run(card_run),
        .card_io(card_io)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse_evt(input logic [3:0] m);
        @(negedge clk);
        evt_in = m;
        repeat (4) @(negedge clk);
        evt_in = '0;
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk("R1 irq", {7'd0, pci_irq}, 8'h00);
        chk("R1 card_run", {7'd0, card_run}, 8'h00);
        rd(8'h03, v); chk("R1 ctl", v, 8'h00);
        rd(8'h04, v); chk("R1 status", v, 8'h00);
        rd(8'h05, v); chk("R1 cfg", v, 8'h00);
        rd(8'h93, v); chk("R1 diag", v, 8'h00);

        // R9: control bits and readback
        wr(8'h03, 8'h60);
        chk("R9 card_run", {7'd0, card_run}, 8'h01);
        chk("R9 card_io", {7'd0, card_io}, 8'h01);
        rd(8'h03, v); chk("R9 ctl readback", v, 8'h60);
        wr(8'h05, 8'hA5); rd(8'h05, v); chk("R9 cfg readback", v, 8'hA5);
        wr(8'h93, 8'h7E); rd(8'h93, v); chk("R9 diag readback", v, 8'h7E);
        wr(8'h03, 8'h40); wr(8'h93, 8'h00); wr(8'h05, 8'h00);
        chk("R9 card_io clear", {7'd0, card_io}, 8'h00);

        // R10: status not writable, unmapped ignored
        wr(8'h04, 8'hFF); rd(8'h04, v); chk("R10 status write", v, 8'h00);
        wr(8'h10, 8'hFF); rd(8'h10, v); chk("R10 unmapped read", v, 8'h00);
        rd(8'h03, v); chk("R10 ctl untouched", v, 8'h40);
        rd(8'h05, v); chk("R10 cfg untouched", v, 8'h00);

        // R2/R3/R4/R6: sweep event patterns and enable masks, routing open via ctl bit
        wr(8'h03, 8'h50);
        for (int en = 0; en < 16; en++) begin
            wr(8'h05, 8'(en));
            for (int ev = 0; ev < 16; ev++) begin
                pulse_evt(4'(ev));
                chk("R6 irq level", {7'd0, pci_irq}, {7'd0, ((ev & en) != 0)});
                rd(8'h04, v);
                chk("R3 status bits", v, 8'(ev));
                @(negedge clk);
                chk("R4 irq after read", {7'd0, pci_irq}, 8'h00);
            end
        end
        rd(8'h04, v); chk("R4 status empty", v, 8'h00);

        // R7/R8: routing sweep
        for (int d = 0; d < 2; d++)
            for (int c4 = 0; c4 < 2; c4++)
                for (int sel = 0; sel < 16; sel++) begin
                    wr(8'h03, 8'h40 | 8'(c4 << 4));
                    wr(8'h93, 8'(d << 5));
                    wr(8'h05, {4'(sel), 4'hF});
                    pulse_evt(4'b1000);
                    if (d == 1)
                        chk("R8 routing by select", {7'd0, pci_irq}, {7'd0, sel == 0});
                    else
                        chk("R7 routing by ctl bit", {7'd0, pci_irq}, 8'(c4));
                    rd(8'h04, v);
                    chk("R3 detect bit", v, 8'h08);
                    @(negedge clk);
                end

        // R11: unread status keeps the interrupt up
        wr(8'h93, 8'h00); wr(8'h03, 8'h50); wr(8'h05, 8'h0F);
        pulse_evt(4'b0100);
        repeat (50) @(negedge clk);
        chk("R11 irq held", {7'd0, pci_irq}, 8'h01);
        rd(8'h04, v); chk("R11 status", v, 8'h04);

        // R2: falling edge sets nothing
        @(negedge clk); evt_in = 4'b0010;
        repeat (4) @(negedge clk);
        rd(8'h04, v); chk("R2 rising latched", v, 8'h02);
        evt_in = 4'b0000;
        repeat (6) @(negedge clk);
        rd(8'h04, v); chk("R2 falling ignored", v, 8'h00);

        // R5: edge lands on the same clock as the read clear
        pulse_evt(4'b0001);
        @(negedge clk); evt_in = 4'b1000;
        @(negedge clk);
        @(negedge clk); bus_addr = 8'h04; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0;
        chk("R5 read returns older flags", bus_rdata, 8'h01);
        rd(8'h04, v); chk("R5 new edge kept", v, 8'h08);
        evt_in = '0;
        repeat (4) @(negedge clk);

        finish_run();
    end
endmodule